// File: doc/BRIEF.md
# Configurable Valid-Ready Register Slice

This block is a single pipeline stage placed on one valid/ready channel. The channel carries a payload of configurable width, such as a command or a data beat. Designers insert it where a long combinational path must be cut. A build-time mode picks which path gets a flop: the forward path (valid and payload), the backward path (ready), both paths, or neither.

Every mode transfers beats in order, without loss and without duplication, under any backpressure from downstream. The forward mode adds one cycle of latency and keeps `ready_src` combinational. The backward mode keeps data combinational and registers `ready_src`. It uses a single side register to park the one beat that can arrive while the registered ready lags. The fully registered mode is a two-entry ping-pong buffer whose not-empty and not-full flags drive `valid_dst` and `ready_src` directly.

Top module: `rvSlice`

## Requirements
- R1: The `MODE` parameter selects the behaviour with the encoding 0 = pass-through, 1 = forward-registered, 2 = backward-registered, 3 = fully registered. A beat offered while downstream is ready appears on `valid_dst` in the same cycle for modes 0 and 2, and one cycle later for modes 1 and 3.
- R2: In pass-through mode, `valid_dst`, `ready_src` and `payload_dst` are combinational copies of `valid_src`, `ready_dst` and `payload_src`.
- R3: In forward mode, `ready_src` equals (NOT `valid_dst`) OR `ready_dst`, so a new beat can enter in the same cycle that the held beat leaves.
- R4: In forward mode, the held payload changes only on an upstream handshake (`valid_src` and `ready_src` both high).
- R5: In backward mode, `ready_src` equals the value `ready_dst` had one cycle earlier.
- R6: In backward mode, a beat accepted while `ready_dst` is low is parked in a side register. It stays presented on `payload_dst` while downstream stalls, and it leaves before any later beat.
- R7: In fully registered mode, `valid_dst` is high exactly when the two-entry buffer is not empty, and `ready_src` is high exactly when it is not full. With downstream stalled, two beats are accepted and the third is refused.
- R8: In forward and fully registered modes, with `valid_src` and `ready_dst` held high, one beat is accepted every clock.
- R9: In every mode, beats reach downstream in arrival order, with none dropped and none duplicated, under arbitrary stall patterns on both sides.
- R10: During and after reset, `valid_dst` is low. In forward and fully registered modes, `payload_dst` is 0 after reset.
- R11: In every mode except pass-through, once `valid_dst` is high while `ready_dst` is low, the next cycle still shows `valid_dst` high with an unchanged `payload_dst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_src | input | 1 | Upstream beat valid |
| ready_src | output | 1 | Slice can accept a beat |
| payload_src | input | WIDTH | Upstream beat payload |
| valid_dst | output | 1 | Downstream beat valid |
| ready_dst | input | 1 | Downstream can accept a beat |
| payload_dst | output | WIDTH | Downstream beat payload |

## Verification
The assertions check, on every cycle, the per-mode flag rules:
- the pass-through copy;
- the forward ready equation;
- the one-cycle lag of the backward ready;
- full implying not empty in the ping-pong buffer;
- the hold of a stalled beat in every registered mode.

Only the bench's scenarios can show the properties that span many beats:
- the end-to-end order and count of beats under random stalls;
- the latency difference between modes;
- the exact capacity of two before refusal;
- sustained single-cycle throughput.

// File: rtl/rvSlicePkg.sv
package rvSlicePkg;

  typedef enum logic [1:0] {
    SLICE_PASS = 2'd0,
    SLICE_FWD  = 2'd1,
    SLICE_BWD  = 2'd2,
    SLICE_FULL = 2'd3
  } sliceMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] load;   // per-slot load enable
    logic       rdSel;  // slot presented downstream
    logic       bypass; // present the incoming payload instead of a slot
  } sliceStrobe_t;

endpackage

// File: rtl/rvSliceCtrl.sv
module rvSliceCtrl
  import rvSlicePkg::*;
#(
  parameter sliceMode_e MODE = SLICE_FULL
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic         readyOut,
  output logic         readyIn,
  output logic         validOut,
  output sliceStrobe_t strb
);

  generate
    if (MODE == SLICE_PASS) begin : g_pass
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign validOut  = validIn;
      assign readyIn   = readyOut;
      assign strb      = '{load: 2'b00, rdSel: 1'b0, bypass: 1'b1};
    end else if (MODE == SLICE_FWD) begin : g_fwd
      logic heldValid;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         heldValid <= 1'b0;
        else if (validIn)  heldValid <= 1'b1;
        else if (readyOut) heldValid <= 1'b0;
      end
      assign readyIn  = !heldValid | readyOut;
      assign validOut = heldValid;
      assign strb     = '{load: {1'b0, validIn & readyIn}, rdSel: 1'b0, bypass: 1'b0};
    end else if (MODE == SLICE_BWD) begin : g_bwd
      logic readyReg;
      logic sideFull;
      logic accept;
      logic park;
      assign accept = validIn & readyReg;
      assign park   = accept & !readyOut & !sideFull;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) readyReg <= 1'b0;
        else       readyReg <= readyOut;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         sideFull <= 1'b0;
        else if (park)     sideFull <= 1'b1;
        else if (readyOut) sideFull <= 1'b0;
      end
      assign readyIn  = readyReg;
      assign validOut = sideFull | accept;
      assign strb     = '{load: {1'b0, park}, rdSel: 1'b0, bypass: !sideFull};
    end else begin : g_full
      localparam int SLOTS = 2;
      localparam int CW    = $clog2(SLOTS + 1);
      localparam logic [CW-1:0] FULLCNT = CW'(SLOTS);
      logic [CW-1:0] count;
      logic          wrPtr;
      logic          rdPtr;
      logic          push;
      logic          pop;
      assign push = validIn & readyIn;
      assign pop  = validOut & readyOut;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          count <= '0;
          wrPtr <= 1'b0;
          rdPtr <= 1'b0;
        end else begin
          if (push && !pop)      count <= count + 1'b1;
          else if (pop && !push) count <= count - 1'b1;
          if (push) wrPtr <= !wrPtr;
          if (pop)  rdPtr <= !rdPtr;
        end
      end
      assign validOut = (count != '0);
      assign readyIn  = (count != FULLCNT);
      assign strb     = '{load: {push & wrPtr, push & !wrPtr}, rdSel: rdPtr, bypass: 1'b0};
    end
  endgenerate

endmodule

// File: rtl/rvSliceData.sv
module rvSliceData
  import rvSlicePkg::*;
#(
  parameter int         WIDTH = 32,
  parameter sliceMode_e MODE  = SLICE_FULL
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] payloadIn,
  input  sliceStrobe_t     strb,
  output logic [WIDTH-1:0] payloadOut
);

  localparam int SLOTS = (MODE == SLICE_FULL) ? 2 : 1;

  logic [WIDTH-1:0] slot [SLOTS];
  logic [WIDTH-1:0] held;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             slot[i] <= '0;
        else if (strb.load[i]) slot[i] <= payloadIn;
      end
    end

    if (SLOTS == 2) begin : g_two
      assign held = slot[strb.rdSel];
    end else begin : g_one
      logic unusedSel;
      assign unusedSel = strb.load[1] ^ strb.rdSel;
      assign held      = slot[0];
    end
  endgenerate

  assign payloadOut = strb.bypass ? payloadIn : held;

endmodule

// File: rtl/rvSlice.sv
module rvSlice
  import rvSlicePkg::*;
#(
  parameter int         WIDTH = 32,
  parameter sliceMode_e MODE  = SLICE_FULL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_src,
  output logic             ready_src,
  input  logic [WIDTH-1:0] payload_src,
  output logic             valid_dst,
  input  logic             ready_dst,
  output logic [WIDTH-1:0] payload_dst
);

  sliceStrobe_t strb;

  rvSliceCtrl #(.MODE(MODE)) uCtrl (
    .clk      (clk),
    .rstN     (rst_n),
    .validIn  (valid_src),
    .readyOut (ready_dst),
    .readyIn  (ready_src),
    .validOut (valid_dst),
    .strb     (strb)
  );

  rvSliceData #(.WIDTH(WIDTH), .MODE(MODE)) uData (
    .clk        (clk),
    .rstN       (rst_n),
    .payloadIn  (payload_src),
    .strb       (strb),
    .payloadOut (payload_dst)
  );

endmodule

// File: rtl/rvSliceChk.sv
module rvSliceChk
  import rvSlicePkg::*;
#(
  parameter int         WIDTH = 32,
  parameter sliceMode_e MODE  = SLICE_FULL
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_src,
  input logic             ready_src,
  input logic [WIDTH-1:0] payload_src,
  input logic             valid_dst,
  input logic             ready_dst,
  input logic [WIDTH-1:0] payload_dst
);

  logic unusedChk;
  assign unusedChk = ^{valid_src, payload_src};

  generate
    if (MODE == SLICE_PASS) begin : g_pass
      a_r2_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_dst == valid_src) && (ready_src == ready_dst) && (payload_dst == payload_src));
    end else begin : g_reg
      a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_dst && !ready_dst) |=> (valid_dst && $stable(payload_dst)));

      if (MODE == SLICE_FWD) begin : g_fwd
        a_r3_fwd_ready: assert property (@(posedge clk) disable iff (!rst_n)
          ready_src == (!valid_dst || ready_dst));
      end

      if (MODE == SLICE_BWD) begin : g_bwd
        a_r5_bwd_ready_lag: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n) |-> (ready_src == $past(ready_dst)));
        a_r6_bwd_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
          (valid_dst && !ready_dst) |=> !ready_src);
      end

      if (MODE == SLICE_FULL) begin : g_full
        a_r7_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
          !ready_src |-> valid_dst);
      end
    end
  endgenerate

endmodule

bind rvSlice rvSliceChk #(.WIDTH(WIDTH), .MODE(MODE)) uChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_src   (valid_src),
  .ready_src   (ready_src),
  .payload_src (payload_src),
  .valid_dst   (valid_dst),
  .ready_dst   (ready_dst),
  .payload_dst (payload_dst)
);

// File: tb/tb_rvSlice.sv
`timescale 1ns/1ps
module tb_rvSlice;
  import rvSlicePkg::*;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]   vSrc;
  logic [3:0]   rSrc;
  logic [3:0]   vDst;
  logic [3:0]   rDst;
  logic [W-1:0] pSrc [4];
  logic [W-1:0] pDst [4];

  for (genvar m = 0; m < 4; m++) begin : g_mode
    rvSlice #(.WIDTH(W), .MODE(sliceMode_e'(m))) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_src   (vSrc[m]),
      .ready_src   (rSrc[m]),
      .payload_src (pSrc[m]),
      .valid_dst   (vDst[m]),
      .ready_dst   (rDst[m]),
      .payload_dst (pDst[m])
    );
  end

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drain(input int m);
    for (int k = 0; k < 4; k++) begin
      step();
      vSrc[m] = 1'b0;
      rDst[m] = 1'b1;
    end
  endtask

  task automatic tReset();
    vSrc = '0;
    rDst = '0;
    for (int m = 0; m < 4; m++) pSrc[m] = '0;
    rst_n = 1'b0;
    step(); step();
    #1;
    for (int m = 1; m < 4; m++) chk($sformatf("R10 valid in reset m%0d", m), W'(vDst[m]), '0);
    rst_n = 1'b1;
    step(); step();
    #1;
    for (int m = 1; m < 4; m++) chk($sformatf("R10 valid after reset m%0d", m), W'(vDst[m]), '0);
    chk("R10 fwd payload after reset", pDst[1], '0);
    chk("R10 full payload after reset", pDst[3], '0);
  endtask

  task automatic tPass();
    for (int k = 0; k < 4; k++) begin
      step();
      vSrc[0] = k[0];
      rDst[0] = k[1];
      pSrc[0] = 32'hA5A5_0000 + k;
      #1;
      chk("R2 valid copy", W'(vDst[0]), W'(k[0]));
      chk("R2 ready copy", W'(rSrc[0]), W'(k[1]));
      chk("R2 payload copy", pDst[0], 32'hA5A5_0000 + k);
    end
    drain(0);
  endtask

  task automatic tLatency();
    for (int m = 0; m < 4; m++) begin
      drain(m);
      step();
      vSrc[m] = 1'b1;
      pSrc[m] = 32'h100 + m;
      #1;
      chk($sformatf("R1 same-cycle valid m%0d", m), W'(vDst[m]), W'(m == 0 || m == 2));
      step();
      vSrc[m] = 1'b0;
      #1;
      chk($sformatf("R1 next-cycle valid m%0d", m), W'(vDst[m]), W'(m == 1 || m == 3));
      if (m == 1 || m == 3) chk($sformatf("R1 next-cycle payload m%0d", m), pDst[m], 32'h100 + m);
      drain(m);
    end
  endtask

  task automatic tFwd();
    drain(1);
    step(); rDst[1] = 1'b0; vSrc[1] = 1'b1; pSrc[1] = 32'hF1; #1;
    chk("R3 empty accepts", W'(rSrc[1]), 1);
    step(); pSrc[1] = 32'hF2; #1;
    chk("R3 held refuses", W'(rSrc[1]), 0);
    chk("R4 held payload", pDst[1], 32'hF1);
    step(); #1;
    chk("R11 fwd stall hold", pDst[1], 32'hF1);
    chk("R11 fwd stall valid", W'(vDst[1]), 1);
    step(); rDst[1] = 1'b1; #1;
    chk("R3 pass-on accepts", W'(rSrc[1]), 1);
    step(); vSrc[1] = 1'b0; #1;
    chk("R4 next payload", pDst[1], 32'hF2);
    chk("R3 next valid", W'(vDst[1]), 1);
    step(); #1;
    chk("R3 empty after drain", W'(vDst[1]), 0);
    drain(1);
  endtask

  task automatic tBwd();
    drain(2);
    step(); rDst[2] = 1'b0; vSrc[2] = 1'b1; pSrc[2] = 32'hB1; #1;
    chk("R5 lagged ready high", W'(rSrc[2]), 1);
    chk("R6 passthrough payload", pDst[2], 32'hB1);
    step(); pSrc[2] = 32'hB2; #1;
    chk("R5 lagged ready low", W'(rSrc[2]), 0);
    chk("R6 parked valid", W'(vDst[2]), 1);
    chk("R6 parked payload", pDst[2], 32'hB1);
    step(); rDst[2] = 1'b1; #1;
    chk("R5 still low", W'(rSrc[2]), 0);
    chk("R6 parked leaves first", pDst[2], 32'hB1);
    step(); #1;
    chk("R5 ready returns", W'(rSrc[2]), 1);
    chk("R6 next beat", pDst[2], 32'hB2);
    step(); vSrc[2] = 1'b0; #1;
    chk("R6 empty", W'(vDst[2]), 0);
    drain(2);
  endtask

  task automatic tFull();
    drain(3);
    step(); rDst[3] = 1'b0; vSrc[3] = 1'b1; pSrc[3] = 32'hC1; #1;
    chk("R7 empty ready", W'(rSrc[3]), 1);
    chk("R7 empty valid", W'(vDst[3]), 0);
    step(); pSrc[3] = 32'hC2; #1;
    chk("R7 one ready", W'(rSrc[3]), 1);
    chk("R7 one payload", pDst[3], 32'hC1);
    step(); pSrc[3] = 32'hC3; #1;
    chk("R7 full refuses", W'(rSrc[3]), 0);
    chk("R11 full hold", pDst[3], 32'hC1);
    step(); rDst[3] = 1'b1; #1;
    chk("R7 still full", W'(rSrc[3]), 0);
    step(); #1;
    chk("R7 room again", W'(rSrc[3]), 1);
    chk("R7 second payload", pDst[3], 32'hC2);
    step(); vSrc[3] = 1'b0; rDst[3] = 1'b0; #1;
    chk("R7 third payload", pDst[3], 32'hC3);
    chk("R7 one left ready", W'(rSrc[3]), 1);
    chk("R7 one left valid", W'(vDst[3]), 1);
    drain(3);
  endtask

  task automatic tThroughput(input int m);
    int ins = 0;
    int outs = 0;
    drain(m);
    for (int k = 0; k < 20; k++) begin
      step();
      vSrc[m] = 1'b1;
      rDst[m] = 1'b1;
      pSrc[m] = W'(k);
      #1;
      if (vSrc[m] && rSrc[m]) ins++;
      if (vDst[m] && rDst[m]) outs++;
    end
    chk($sformatf("R8 accepts m%0d", m), W'(ins), 20);
    chk($sformatf("R8 delivers m%0d", m), W'(outs), 19);
    drain(m);
  endtask

  task automatic tStream(input int m, input int pv, input int pr);
    logic [W-1:0] q [$];
    logic [W-1:0] data = '0;
    logic pending = 1'b0;
    int sent = 0;
    int got = 0;
    int n = 150;
    drain(m);
    for (int c = 0; c < 4000 && got < n; c++) begin
      step();
      if (!pending && sent < n && $urandom_range(99) < pv) begin
        pending = 1'b1;
        data = $urandom;
      end
      vSrc[m] = pending;
      pSrc[m] = data;
      rDst[m] = ($urandom_range(99) < pr);
      #1;
      if (vSrc[m] && rSrc[m]) begin
        q.push_back(data);
        pending = 1'b0;
        sent++;
      end
      if (vDst[m] && rDst[m]) begin
        if (q.size() == 0) begin
          chk($sformatf("R9 duplicate beat m%0d", m), pDst[m], 'x);
        end else begin
          chk($sformatf("R9 order m%0d", m), pDst[m], q.pop_front());
        end
        got++;
      end
    end
    chk($sformatf("R9 delivered count m%0d", m), W'(got), W'(n));
    drain(m);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R9 watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    tReset();
    tPass();
    tLatency();
    tFwd();
    tBwd();
    tFull();
    tThroughput(1);
    tThroughput(3);
    for (int m = 0; m < 4; m++) begin
      tStream(m, 80, 30);
      tStream(m, 40, 90);
    end
    finishRun();
  end

endmodule